// File: doc/BRIEF.md
# Per-Pin Input Event Interrupt Detector

This block watches up to 32 already-synchronized input pins beside a general-purpose I/O port and raises one combined interrupt when any pin meets the condition chosen for it. Each pin has its own small control word. A 4-bit condition code in that word arms the pin for a low level, a high level, a rising edge, a falling edge or either edge, or leaves it idle.

Every detected event sets that pin's bit in a shared flag word. Software reads the flag word to find the pins that fired, and clears bits by writing ones to them. The registered OR of all flags forms the single interrupt request.

Access is through a simple synchronous register bus. A write strobe lands in the same clock edge. A read strobe returns its data on `bus_rdata` one cycle later. Edge detection compares each pin's current sample with the sample taken one clock earlier.

Top module: `pin_event_irq`

## Requirements
- R1: Pin n owns a control word at byte address 4*n (n = 0..31). Its condition code sits in bits 19:16. A write stores only those four bits. Reading the word returns the stored code in bits 19:16 and zeros elsewhere, on `bus_rdata` one cycle after the read strobe.
- R2: With code 0x9, a pin's flag is set on the first clock edge where the pin samples 1 after having sampled 0 on the previous edge. A high-to-low change sets nothing.
- R3: With code 0xA, the flag is set on a high-to-low change only. A low-to-high change sets nothing.
- R4: With code 0xB, the flag is set on a change in either direction.
- R5: With code 0x8, the flag is set on every clock edge where the pin is 0. A clear written while the pin is still low leaves the flag set.
- R6: With code 0xC, the flag is set on every clock edge where the pin is 1. A clear written while the pin is still high leaves the flag set.
- R7: Code 0x0 and every code outside {0x8, 0x9, 0xA, 0xB, 0xC} never set a flag. An unlisted code still reads back as written. Writing zero to a pin's control word stops detection for that pin.
- R8: Reset clears all control words, all flags, the interrupt output and the stored previous pin samples (taken as 0).
- R9: The flag word is at byte address 0xA0, with bit n belonging to pin n. Writing 1 to a bit clears that flag, and writing 0 leaves it unchanged. A read returns the current flags.
- R10: When an event for a pin occurs on the same edge as a clear of that pin's flag, the flag ends up set.
- R11: `irq_out` is a register holding the OR of all flags. It rises one clock after the first flag is set and falls one clock after the last flag is cleared.
- R12: Writes to addresses that are neither a control word nor the flag word change nothing, and reads of such addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data follows one cycle later |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Synchronized pin levels |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach from the ports is a clear and a new event landing on the same edge. The stimulus produces it by changing an edge-armed pin on the same clock as the write-one-to-clear bus cycle. It then reads back that the flag survived.

A related case is a clear issued while a level-armed pin stays active. The bench holds the level, clears, and confirms the flag is back. It then releases the pin and clears again, and confirms the flag is gone.

The registered interrupt is probed on the exact cycles around a flag change, to tell it apart from a combinational OR.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;

  localparam int CODE_W   = 4;
  localparam int CODE_LSB = 16;

  typedef enum logic [CODE_W-1:0] {
    COND_OFF    = 4'h0,
    COND_LVL_LO = 4'h8,
    COND_RISE   = 4'h9,
    COND_FALL   = 4'hA,
    COND_BOTH   = 4'hB,
    COND_LVL_HI = 4'hC
  } cond_e;

  // Evaluate one pin's condition from its current and previous sample.
  function automatic logic cond_hit(input logic [CODE_W-1:0] code,
                                    input logic cur, input logic prv);
    logic hit;
    case (code)
      COND_LVL_LO: hit = ~cur;
      COND_LVL_HI: hit = cur;
      COND_RISE:   hit = cur & ~prv;
      COND_FALL:   hit = ~cur & prv;
      COND_BOTH:   hit = cur ^ prv;
      default:     hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/pin_event_regs.sv
module pin_event_regs
  import pin_event_pkg::*;
#(
  parameter int NPINS      = 32,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int STATUS_OFS = 'hA0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  input  logic [NPINS-1:0]        flags_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic [NPINS*CODE_W-1:0] codes_o,
  output logic [NPINS-1:0]        clr_o
);

  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STATUS_OFS);

  logic status_hit;
  assign status_hit = (bus_addr == STAT_ADDR);

  // One control word per pin; only the condition field is stored.
  for (genvar g = 0; g < NPINS; g++) begin : g_ctrl
    logic              code_en;
    logic [CODE_W-1:0] code_d;
    logic [CODE_W-1:0] code_q;

    always_comb begin
      code_en = bus_wr && (bus_addr == ADDR_W'(g * 4));
      code_d  = bus_wdata[CODE_LSB +: CODE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       code_q <= '0;
      else if (code_en) code_q <= code_d;
    end

    assign codes_o[g*CODE_W +: CODE_W] = code_q;
  end

  // Write-one-to-clear pulses toward the flag word.
  always_comb begin
    clr_o = '0;
    if (bus_wr && status_hit) clr_o = bus_wdata[NPINS-1:0];
  end

  // Read mux, registered under the read strobe.
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    for (int n = 0; n < NPINS; n++) begin
      if (bus_addr == ADDR_W'(n * 4))
        rd_d[CODE_LSB +: CODE_W] = codes_o[n*CODE_W +: CODE_W];
    end
    if (status_hit) rd_d[NPINS-1:0] = flags_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_o <= '0;
    else if (bus_rd) rdata_o <= rd_d;
  end

endmodule

// File: rtl/pin_event_detect.sv
module pin_event_detect
  import pin_event_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPINS-1:0]        pins_i,
  input  logic [NPINS*CODE_W-1:0] codes_i,
  output logic [NPINS-1:0]        evt_o
);

  logic [NPINS-1:0] prev_d;
  logic [NPINS-1:0] prev_q;

  always_comb prev_d = pins_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    always_comb evt_o[g] = cond_hit(codes_i[g*CODE_W +: CODE_W], pins_i[g], prev_q[g]);
  end

endmodule

// File: rtl/pin_event_flags.sv
module pin_event_flags #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] evt_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] flags_o,
  output logic             irq_o
);

  logic [NPINS-1:0] flags_d;
  logic             irq_d;

  // A new event overrides a clear on the same edge.
  always_comb begin
    flags_d = (flags_o & ~clr_i) | evt_i;
    irq_d   = |flags_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      flags_o <= flags_d;
      irq_o   <= irq_d;
    end
  end

endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq
  import pin_event_pkg::*;
#(
  parameter int NPINS      = 32,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int STATUS_OFS = 'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic              irq_out
);

  logic [NPINS*CODE_W-1:0] codes_w;
  logic [NPINS-1:0]        evt_w;
  logic [NPINS-1:0]        clr_w;
  logic [NPINS-1:0]        flags_w;

  pin_event_regs #(
    .NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATUS_OFS(STATUS_OFS)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .flags_i(flags_w),
    .rdata_o(bus_rdata), .codes_o(codes_w), .clr_o(clr_w)
  );

  pin_event_detect #(.NPINS(NPINS)) detect_i (
    .clk(clk), .rst_n(rst_n), .pins_i(pin_in), .codes_i(codes_w), .evt_o(evt_w)
  );

  pin_event_flags #(.NPINS(NPINS)) flags_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_w), .clr_i(clr_w),
    .flags_o(flags_w), .irq_o(irq_out)
  );

endmodule

// File: rtl/pin_event_irq_chk.sv
module pin_event_irq_chk
  import pin_event_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NPINS*CODE_W-1:0] codes,
  input logic [NPINS-1:0]        evt,
  input logic [NPINS-1:0]        clr,
  input logic [NPINS-1:0]        flags,
  input logic                    irq_out
);

  // R11: interrupt is the OR of the flags one edge earlier.
  p_irq_or_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == $past(|flags)));

  // R10: an event always leaves its flag set, cleared or not.
  p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((flags & $past(evt)) == $past(evt)));

  // R9: a cleared bit with no new event goes to zero.
  p_w1c_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~evt)) |=> ((flags & $past(clr & ~evt)) == '0));

  // R9: no flag appears without an event.
  p_no_spurious_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(evt)) == '0));

  // R7: unarmed pins produce no events.
  for (genvar g = 0; g < NPINS; g++) begin : g_idle
    logic armed;
    always_comb begin
      case (codes[g*CODE_W +: CODE_W])
        4'h8, 4'h9, 4'hA, 4'hB, 4'hC: armed = 1'b1;
        default:                      armed = 1'b0;
      endcase
    end
    p_idle_code_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> !evt[g]);
  end

endmodule

bind pin_event_irq pin_event_irq_chk #(.NPINS(NPINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .codes(codes_w), .evt(evt_w),
  .clr(clr_w), .flags(flags_w), .irq_out(irq_out)
);

// File: tb/pin_event_irq_tb_top.sv
`timescale 1ns/1ps
module pin_event_irq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic        irq_out;

  always #2 clk = ~clk;

  pin_event_irq dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .irq_out(irq_out)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_pend = 1'b0;

  task automatic compare(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per completed read.
  always @(posedge clk) rd_pend <= bus_rd;
  always @(negedge clk) begin
    if (rd_pend && !done) begin
      if (exp_q.size() == 0) compare("queue_empty", 32'h1, 32'h0);
      else compare(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic wr_pin(input logic [7:0] a, input logic [31:0] d, input int idx, input logic v);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d; pin_in[idx] = v;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic setpin(input int idx, input logic v);
    @(negedge clk); pin_in[idx] = v;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    compare(tag, {31'b0, irq_out}, {31'b0, exp});
  endtask

  task automatic summary();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  localparam logic [7:0] STAT = 8'hA0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 reset state
    chk_irq(1'b0, "R8 irq after reset");
    rd(STAT,  32'h0, "R8 flags after reset");
    rd(8'h00, 32'h0, "R8 ctrl0 after reset");
    rd(8'h7C, 32'h0, "R8 ctrl31 after reset");

    // R1 field masking, R2 rising edge, R11 timing
    wr(8'h0C, 32'hFFF9_FFFF);
    rd(8'h0C, 32'h0009_0000, "R1 ctrl3 readback");
    setpin(3, 1'b1);
    rd(STAT, 32'h0000_0008, "R2 rise sets pin3");
    wr(STAT, 32'h0000_0008);
    rd(STAT, 32'h0, "R2 cleared");
    setpin(3, 1'b0);
    rd(STAT, 32'h0, "R2 fall ignored");
    tick();
    chk_irq(1'b0, "R11 irq low with no flags");
    setpin(3, 1'b1);
    tick();
    chk_irq(1'b0, "R11 irq one cycle behind flag");
    tick();
    chk_irq(1'b1, "R11 irq raised");
    wr(STAT, 32'h0000_0008);
    chk_irq(1'b1, "R11 irq still high on clear cycle");
    tick();
    chk_irq(1'b0, "R11 irq dropped");
    wr(8'h0C, 32'h0);
    setpin(3, 1'b0);

    // R3 falling edge
    wr(8'h14, 32'h000A_0000);
    setpin(5, 1'b1);
    rd(STAT, 32'h0, "R3 rise ignored");
    setpin(5, 1'b0);
    rd(STAT, 32'h0000_0020, "R3 fall sets pin5");
    wr(STAT, 32'h0000_0020);
    wr(8'h14, 32'h0);

    // R4 either edge
    wr(8'h1C, 32'h000B_0000);
    setpin(7, 1'b1);
    rd(STAT, 32'h0000_0080, "R4 rise sets pin7");
    wr(STAT, 32'h0000_0080);
    rd(STAT, 32'h0, "R4 cleared");
    setpin(7, 1'b0);
    rd(STAT, 32'h0000_0080, "R4 fall sets pin7");
    wr(STAT, 32'h0000_0080);
    wr(8'h1C, 32'h0);

    // R5 level low
    wr(8'h24, 32'h0008_0000);
    rd(STAT, 32'h0000_0200, "R5 low level sets pin9");
    wr(STAT, 32'h0000_0200);
    rd(STAT, 32'h0000_0200, "R5 clear while low does not stick");
    setpin(9, 1'b1);
    wr(STAT, 32'h0000_0200);
    rd(STAT, 32'h0, "R5 clear after release");
    wr(8'h24, 32'h0);
    setpin(9, 1'b0);

    // R6 level high
    wr(8'h7C, 32'h000C_0000);
    rd(STAT, 32'h0, "R6 no flag while low");
    setpin(31, 1'b1);
    rd(STAT, 32'h8000_0000, "R6 high level sets pin31");
    wr(STAT, 32'h8000_0000);
    rd(STAT, 32'h8000_0000, "R6 clear while high does not stick");
    setpin(31, 1'b0);
    wr(STAT, 32'h8000_0000);
    rd(STAT, 32'h0, "R6 clear after release");
    wr(8'h7C, 32'h0);

    // R7 unlisted codes and write-zero disable
    wr(8'h30, 32'h0005_0000);
    wr(8'h34, 32'h000D_0000);
    rd(8'h30, 32'h0005_0000, "R7 unlisted code reads back");
    setpin(12, 1'b1);
    setpin(12, 1'b0);
    rd(STAT, 32'h0, "R7 unlisted codes quiet");
    wr(8'h30, 32'h0);
    wr(8'h34, 32'h0);
    wr(8'h38, 32'h000C_0000);
    setpin(14, 1'b1);
    rd(STAT, 32'h0000_4000, "R7 pin14 armed high");
    wr(8'h38, 32'h0);
    wr(STAT, 32'h0000_4000);
    rd(STAT, 32'h0, "R7 write zero disables pin14");
    setpin(14, 1'b0);

    // R9 write-one-to-clear selectivity
    wr(8'h0C, 32'h0009_0000);
    wr(8'h14, 32'h0009_0000);
    @(negedge clk); pin_in[3] = 1'b1; pin_in[5] = 1'b1;
    rd(STAT, 32'h0000_0028, "R9 two flags set");
    wr(STAT, 32'h0000_0008);
    rd(STAT, 32'h0000_0020, "R9 only pin3 cleared");
    wr(STAT, 32'h0);
    rd(STAT, 32'h0000_0020, "R9 zero write leaves flags");
    chk_irq(1'b1, "R9 irq held by pin5");
    wr(STAT, 32'h0000_0020);

    // R10 event beats clear on same edge
    @(negedge clk); pin_in[3] = 1'b0; pin_in[5] = 1'b0;
    setpin(5, 1'b1);
    rd(STAT, 32'h0000_0020, "R10 pin5 flag before clear");
    wr_pin(STAT, 32'h0000_0020, 3, 1'b1);
    rd(STAT, 32'h0000_0008, "R10 pin3 set during clear of pin5");
    wr_pin(STAT, 32'h0000_0008, 5, 1'b0);
    setpin(5, 1'b1);
    wr_pin(STAT, 32'h0000_0020, 5, 1'b0);
    rd(STAT, 32'h0, "R10 setup idle");
    wr_pin(STAT, 32'h0000_0020, 5, 1'b1);
    rd(STAT, 32'h0000_0020, "R10 same-pin event wins");
    wr(STAT, 32'hFFFF_FFFF);
    wr(8'h0C, 32'h0);
    wr(8'h14, 32'h0);

    // R12 unmapped addresses
    wr(8'h00, 32'h0009_0000);
    wr(8'h80, 32'hFFFF_FFFF);
    wr(8'hA4, 32'hFFFF_FFFF);
    rd(8'h80, 32'h0, "R12 unmapped reads zero");
    rd(8'h00, 32'h0009_0000, "R12 ctrl0 untouched");
    rd(STAT,  32'h0, "R12 flags untouched");
    chk_irq(1'b0, "R12 irq quiet");

    repeat (3) tick();
    if (exp_q.size() != 0) compare("queue_drain", exp_q.size(), 0);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

endmodule